// File: doc/BRIEF.md
# Faulty-Bank Lookup and Repair-Line Remapper

This block sits on the request path of a memory controller. Each request gives a cache-line address and the device ID in the rank that the access concerns. The block looks up a small direct-mapped table with one bank bitmap per DIMM. If the addressed bank is not flagged, it reports that no repair is needed. Most traffic stops there, and no extra cache lookup follows.

When the bank is flagged, the block builds a cache address for the coalesced repair line. Several codewords that differ only in the low column bits share one line. Those bits become the slot within the line. The set index adds the bank, column and row bits to a scaled device ID. Repair lines from different devices at the same location therefore land in different sets, instead of piling into the sets that normal interleaving would pick.

The table is loaded through a one-entry-per-cycle write port. The result appears one clock after the request.

Top module: `fault_remap`

## Requirements
- R1: After reset every table entry is zero, so every request reports a miss and `rsp_valid` is low until the first request.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R3: The DIMM index is `{ch, rank}`. Line address bits, LSB first: ch[0], col[8:1], rank[10:9], bank[13:11], row[21:14]. `rsp_hit` is set when bit `bank` of the entry for that DIMM is 1.
- R4: On a miss with `rsp_valid` high, `rsp_set`, `rsp_tag` and `rsp_slot` are all zero.
- R5: On a hit, `rsp_set` = ({bank, col[7:4]} + row + dev*8) mod 256.
- R6: On a hit, `rsp_tag` = {ch, rank, dev, row, bank, col[7:4]}, which is 23 bits.
- R7: On a hit, `rsp_slot` = col[3:0].
- R8: Hits that differ only in col[3:0] return the same set and tag.
- R9: A table write affects requests from the next cycle on. A request in the same cycle as the write sees the old entry.
- R10: A write to one DIMM's entry does not change the lookup result for any other DIMM.
- R11: A write replaces the whole entry, so cleared bits stop flagging their banks.
- R12: The 32 device IDs at one location give 32 distinct sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_dimm | input | 3 | DIMM entry to write |
| wr_map | input | 8 | New bank bitmap for that entry |
| req_valid | input | 1 | Request present |
| req_line | input | 22 | Cache-line address (offset stripped) |
| req_dev | input | 5 | Device ID within the rank |
| rsp_valid | output | 1 | Result valid (one cycle after request) |
| rsp_hit | output | 1 | Addressed bank is flagged faulty |
| rsp_set | output | 8 | Remapped cache set index |
| rsp_tag | output | 23 | Remapped cache tag |
| rsp_slot | output | 4 | Slot within the coalesced line |

## Verification
The checks assume that `req_valid` and `wr_en` are driven low during reset and carry no unknown values after it. They also assume that the address and device fields are stable within the cycle where they are sampled. The stimulus changes inputs only on falling edges and idles the request and write strobes between operations. The one same-cycle write-and-request case is a deliberate overlap, used to pin down which table value the lookup sees.

// File: rtl/fault_remap_pkg.sv
package fault_remap_pkg;
  localparam int DEF_CH_W   = 1;
  localparam int DEF_RANK_W = 2;
  localparam int DEF_COL_W  = 8;
  localparam int DEF_BANK_W = 3;
  localparam int DEF_ROW_W  = 8;
  localparam int DEF_SLOT_W = 4;
  localparam int DEF_DEV_W  = 5;
  localparam int DEF_SET_W  = 8;
endpackage

// File: rtl/fault_table.sv
module fault_table #(
  parameter int DIMM_W = 3,
  parameter int MAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DIMM_W-1:0] wr_dimm,
  input  logic [MAP_W-1:0]  wr_map,
  input  logic [DIMM_W-1:0] rd_dimm,
  output logic [MAP_W-1:0]  rd_map
);
  localparam int ENTRIES = 2 ** DIMM_W;

  logic [MAP_W-1:0] ent_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             ld;
    logic [MAP_W-1:0] ent_d;

    always_comb begin
      ld    = wr_en && (wr_dimm == DIMM_W'(e));
      ent_d = ld ? wr_map : ent_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[e] <= '0;
      else        ent_q[e] <= ent_d;
    end
  end

  assign rd_map = ent_q[rd_dimm];
endmodule

// File: rtl/remap_calc.sv
module remap_calc #(
  parameter int CH_W   = 1,
  parameter int RANK_W = 2,
  parameter int COL_W  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  parameter int SLOT_W = 4,
  parameter int DEV_W  = 5,
  parameter int SET_W  = 8,
  localparam int HI_W  = COL_W - SLOT_W,
  localparam int TAG_W = CH_W + RANK_W + DEV_W + ROW_W + BANK_W + HI_W
) (
  input  logic [CH_W-1:0]   ch,
  input  logic [RANK_W-1:0] rank,
  input  logic [COL_W-1:0]  col,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [DEV_W-1:0]  dev,
  output logic [SET_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag,
  output logic [SLOT_W-1:0] slot
);
  localparam int DEV_SHIFT = (SET_W > DEV_W) ? SET_W - DEV_W : 0;

  logic [HI_W-1:0]  col_hi;
  logic [SET_W-1:0] term_bc, term_row, term_dev;

  always_comb begin
    col_hi   = col[COL_W-1:SLOT_W];
    term_bc  = SET_W'({bank, col_hi});
    term_row = SET_W'(row);
    term_dev = SET_W'(dev) << DEV_SHIFT;
    set_idx  = term_bc + term_row + term_dev;
    tag      = {ch, rank, dev, row, bank, col_hi};
    slot     = col[SLOT_W-1:0];
  end
endmodule

// File: rtl/fault_remap.sv
module fault_remap
  import fault_remap_pkg::*;
#(
  parameter int CH_W   = DEF_CH_W,
  parameter int RANK_W = DEF_RANK_W,
  parameter int COL_W  = DEF_COL_W,
  parameter int BANK_W = DEF_BANK_W,
  parameter int ROW_W  = DEF_ROW_W,
  parameter int SLOT_W = DEF_SLOT_W,
  parameter int DEV_W  = DEF_DEV_W,
  parameter int SET_W  = DEF_SET_W,
  localparam int DIMM_W   = CH_W + RANK_W,
  localparam int MAP_W    = 2 ** BANK_W,
  localparam int COL_LSB  = CH_W,
  localparam int RANK_LSB = COL_LSB + COL_W,
  localparam int BANK_LSB = RANK_LSB + RANK_W,
  localparam int ROW_LSB  = BANK_LSB + BANK_W,
  localparam int ADDR_W   = ROW_LSB + ROW_W,
  localparam int TAG_W    = DIMM_W + DEV_W + ROW_W + BANK_W + COL_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DIMM_W-1:0] wr_dimm,
  input  logic [MAP_W-1:0]  wr_map,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_line,
  input  logic [DEV_W-1:0]  req_dev,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [SET_W-1:0]  rsp_set,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [SLOT_W-1:0] rsp_slot
);
  logic [CH_W-1:0]   f_ch;
  logic [COL_W-1:0]  f_col;
  logic [RANK_W-1:0] f_rank;
  logic [BANK_W-1:0] f_bank;
  logic [ROW_W-1:0]  f_row;
  logic [MAP_W-1:0]  bank_map;
  logic [SET_W-1:0]  c_set;
  logic [TAG_W-1:0]  c_tag;
  logic [SLOT_W-1:0] c_slot;

  assign f_ch   = req_line[0 +: CH_W];
  assign f_col  = req_line[COL_LSB +: COL_W];
  assign f_rank = req_line[RANK_LSB +: RANK_W];
  assign f_bank = req_line[BANK_LSB +: BANK_W];
  assign f_row  = req_line[ROW_LSB +: ROW_W];

  fault_table #(.DIMM_W(DIMM_W), .MAP_W(MAP_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_dimm (wr_dimm),
    .wr_map  (wr_map),
    .rd_dimm ({f_ch, f_rank}),
    .rd_map  (bank_map)
  );

  remap_calc #(
    .CH_W(CH_W), .RANK_W(RANK_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .SLOT_W(SLOT_W), .DEV_W(DEV_W), .SET_W(SET_W)
  ) u_calc (
    .ch      (f_ch),
    .rank    (f_rank),
    .col     (f_col),
    .bank    (f_bank),
    .row     (f_row),
    .dev     (req_dev),
    .set_idx (c_set),
    .tag     (c_tag),
    .slot    (c_slot)
  );

  // next state
  logic              hit_d;
  logic [SET_W-1:0]  set_d;
  logic [TAG_W-1:0]  tag_d;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    hit_d  = req_valid && bank_map[f_bank];
    set_d  = hit_d ? c_set  : '0;
    tag_d  = hit_d ? c_tag  : '0;
    slot_d = hit_d ? c_slot : '0;
  end

  // registers; payload loads only with a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_set  <= '0;
      rsp_tag  <= '0;
      rsp_slot <= '0;
    end else if (req_valid) begin
      rsp_set  <= set_d;
      rsp_tag  <= tag_d;
      rsp_slot <= slot_d;
    end
  end
endmodule

// File: rtl/fault_remap_chk.sv
module fault_remap_chk #(
  parameter int ADDR_W  = 22,
  parameter int COL_LSB = 1,
  parameter int SLOT_W  = 4,
  parameter int DEV_W   = 5,
  parameter int SET_W   = 8,
  parameter int TAG_W   = 23,
  parameter int HI_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_line,
  input logic [DEV_W-1:0]  req_dev,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [SET_W-1:0]  rsp_set,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [SLOT_W-1:0] rsp_slot
);
  localparam int TDEV_LSB = TAG_W - DEV_W - (ADDR_W - COL_LSB - SLOT_W - HI_W)
                            - (COL_LSB == 0 ? 0 : 0);

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_set == '0 && rsp_tag == '0 && rsp_slot == '0));

  // R7
  slot_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_slot == $past(req_line[COL_LSB +: SLOT_W])));

  // R6
  tag_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit ||
      rsp_tag[HI_W-1:0] == $past(req_line[COL_LSB+SLOT_W +: HI_W])));
endmodule

bind fault_remap fault_remap_chk #(
  .ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .SLOT_W(SLOT_W), .DEV_W(DEV_W),
  .SET_W(SET_W), .TAG_W(TAG_W), .HI_W(COL_W - SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
  .req_dev(req_dev), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_set(rsp_set), .rsp_tag(rsp_tag), .rsp_slot(rsp_slot)
);

// File: tb/fault_remap_test.sv
module fault_remap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_dimm = '0;
  logic [7:0]  wr_map = '0;
  logic        req_valid = 1'b0;
  logic [21:0] req_line = '0;
  logic [4:0]  req_dev = '0;
  logic        rsp_valid, rsp_hit;
  logic [7:0]  rsp_set;
  logic [22:0] rsp_tag;
  logic [3:0]  rsp_slot;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_remap uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dimm(wr_dimm), .wr_map(wr_map),
    .req_valid(req_valid), .req_line(req_line), .req_dev(req_dev),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_set(rsp_set),
    .rsp_tag(rsp_tag), .rsp_slot(rsp_slot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input logic ch, input logic [1:0] rk,
      input logic [2:0] bk, input logic [7:0] row, input logic [7:0] col);
    return {row, bk, rk, col, ch};
  endfunction

  function automatic logic [7:0] e_set(input logic [2:0] bk, input logic [7:0] row,
      input logic [7:0] col, input logic [4:0] dev);
    return 8'({1'b0, bk, col[7:4]} + row + {dev, 3'b000});
  endfunction

  function automatic logic [22:0] e_tag(input logic ch, input logic [1:0] rk,
      input logic [2:0] bk, input logic [7:0] row, input logic [7:0] col,
      input logic [4:0] dev);
    return {ch, rk, dev, row, bk, col[7:4]};
  endfunction

  task automatic wr(input logic [2:0] d, input logic [7:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_dimm = d; wr_map = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic ch, input logic [1:0] rk, input logic [2:0] bk,
      input logic [7:0] row, input logic [7:0] col, input logic [4:0] dev);
    @(negedge clk);
    req_valid = 1'b1; req_line = mk(ch, rk, bk, row, col); req_dev = dev;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid after reset", rsp_valid, 0);
    look(1, 2'd1, 3'd2, 8'h10, 8'h35, 5'd3);
    check("R1 cleared table miss", rsp_hit, 0);
    check("R2 valid", rsp_valid, 1);
  endtask

  task automatic t_hit;
    wr(3'd5, 8'h04);
    look(1, 2'd1, 3'd2, 8'h9C, 8'hA7, 5'd6);
    check("R3 hit", rsp_hit, 1);
    check("R5 set", rsp_set, e_set(3'd2, 8'h9C, 8'hA7, 5'd6));
    check("R6 tag", rsp_tag, e_tag(1, 2'd1, 3'd2, 8'h9C, 8'hA7, 5'd6));
    check("R7 slot", rsp_slot, 4'h7);
    look(1, 2'd1, 3'd3, 8'h9C, 8'hA7, 5'd6);
    check("R3 unflagged bank", rsp_hit, 0);
    check("R4 set zero", rsp_set, 0);
    check("R4 tag zero", rsp_tag, 0);
    check("R4 slot zero", rsp_slot, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R2 idle", rsp_valid, 0);
  endtask

  task automatic t_other;
    look(1, 2'd0, 3'd2, 8'h9C, 8'hA7, 5'd6);
    check("R10 other dimm", rsp_hit, 0);
    look(0, 2'd1, 3'd2, 8'h9C, 8'hA7, 5'd6);
    check("R10 other channel", rsp_hit, 0);
  endtask

  task automatic t_coalesce;
    logic [7:0]  s0;
    logic [22:0] g0;
    look(1, 2'd1, 3'd2, 8'h41, 8'h50, 5'd17);
    s0 = rsp_set; g0 = rsp_tag;
    check("R8 slot0", rsp_slot, 0);
    look(1, 2'd1, 3'd2, 8'h41, 8'h5F, 5'd17);
    check("R8 same set", rsp_set, s0);
    check("R8 same tag", rsp_tag, g0);
    check("R8 slotF", rsp_slot, 4'hF);
  endtask

  task automatic t_spread;
    bit [255:0] seen = '0;
    int dup = 0;
    for (int d = 0; d < 32; d++) begin
      look(1, 2'd1, 3'd2, 8'hE3, 8'hC9, 5'(d));
      check("R12 hit", rsp_hit, 1);
      check("R5 set sweep", rsp_set, e_set(3'd2, 8'hE3, 8'hC9, 5'(d)));
      if (seen[rsp_set]) dup++;
      seen[rsp_set] = 1'b1;
    end
    check("R12 distinct sets", dup, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_dimm = 3'd2; wr_map = 8'h80;
    req_valid = 1'b1; req_line = mk(0, 2'd2, 3'd7, 8'h01, 8'h02); req_dev = 5'd1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 same-cycle old", rsp_hit, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next-cycle new", rsp_hit, 1);
  endtask

  task automatic t_overwrite;
    wr(3'd5, 8'h08);
    look(1, 2'd1, 3'd2, 8'h9C, 8'hA7, 5'd6);
    check("R11 cleared bit", rsp_hit, 0);
    look(1, 2'd1, 3'd3, 8'h9C, 8'hA7, 5'd6);
    check("R11 new bit", rsp_hit, 1);
    look(0, 2'd2, 3'd7, 8'h01, 8'h02, 5'd1);
    check("R10 dimm2 kept", rsp_hit, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hit;
    t_idle;
    t_other;
    t_coalesce;
    t_spread;
    t_timing;
    t_overwrite;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule